// File: doc/BRIEF.md
# Serial Configuration Bus Host Engine

This block is the host end of a four-wire serial configuration bus. A parallel request carries a start strobe, a write/not-read flag, a 12-bit register address and 32 bits of write data. The engine turns each request into bus waveforms: a serial clock, a serial data output, a select line that marks writes, and a load strobe. For reads, it also samples the returned serial data and assembles it into a 32-bit word. When the transaction ends, it raises a one-cycle done strobe.

All bus timing comes from one unit that lasts `UNIT_CLKS` system clocks. Every phase of a transaction lasts a whole number of units. A single down-counter times every phase, so the same design can drive a slow off-chip target or a fast on-chip one without changing the sequencer.

A write sends the address, then the data, then a load cycle. A read sends the address, then a load cycle, then 32 input clock pulses. The engine gathers the input bits least significant first.

Top module: `sercfg_host`

## Requirements
- R1: After reset, and whenever no transaction is in flight, `sc_clk`, `sc_dout`, `sc_sel`, `sc_load` and `rsp_done` are low. `rsp_rdata` resets to zero.
- R2: When idle, a high `req_start` starts a transaction. The 12 address bits go out most significant first. Each bit is placed on `sc_dout` while `sc_clk` is low for one unit, then `sc_clk` is high for one unit. One unit is `UNIT_CLKS` system clocks.
- R3: On a write, the 32 data bits follow the address, most significant first, with the same bit timing. Exactly 44 rising clock edges occur before the load strobe.
- R4: On a write, `sc_sel` rises one unit before the first address bit and stays high until the load cycle has finished. On a read, `sc_sel` is never high.
- R5: After the last shifted bit, `sc_dout` is low for one unit. Then `sc_load` rises with `sc_clk` low for two units. Then `sc_clk` is high for three units while `sc_load` stays high. Both fall together, followed by a two-unit settle.
- R6: On a read, exactly 32 clock pulses follow the load cycle. Each pulse is one unit low, two units high and one unit low. `sc_din` is sampled at the end of that last unit. The first sample lands in bit 0 of `rsp_rdata` and the last in bit 31.
- R7: `rsp_done` is high for exactly one system clock at the end of every transaction. On a read, `rsp_rdata` holds the assembled word in that cycle.
- R8: A `req_start` raised while a transaction is in flight is ignored. It produces no bus activity and no `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Start a transaction (taken only when idle) |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle end-of-transaction strobe |
| rsp_rdata | output | 32 | Assembled read word |
| sc_clk | output | 1 | Serial bus clock |
| sc_dout | output | 1 | Serial data to the target |
| sc_sel | output | 1 | Write select |
| sc_load | output | 1 | Load strobe |
| sc_din | input | 1 | Serial data from the target |

## Verification
The hardest situation to reach from the ports is a start request that arrives while a transaction is still running. The bench raises `req_start` with a different address and direction partway through a write. It then checks that the bus carries only the original write, that exactly one done strobe appears, and that the bus stays quiet afterwards. Bit order on the input side is also easy to get backwards, so the bench uses read words that are not palindromes, such as 0x80000001 and 0x12345678. It acts as a serial target, driving one bit after each falling edge, so any reversal shows up in `rsp_rdata`.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SEL,
      ST_BIT_LO,
      ST_BIT_HI,
      ST_GAP,
      ST_LD_SET,
      ST_LD_HI,
      ST_LD_END,
      ST_RD_LO,
      ST_RD_HI,
      ST_RD_POST,
      ST_DONE
   } seq_state_t;

   localparam int unsigned MAX_PHASE_UNITS = 3;

   // length of each timed phase, in timing units
   function automatic logic [1:0] phase_units(seq_state_t s);
      case (s)
         ST_LD_SET:  phase_units = 2'd2;
         ST_LD_HI:   phase_units = 2'd3;
         ST_LD_END:  phase_units = 2'd2;
         ST_RD_HI:   phase_units = 2'd2;
         default:    phase_units = 2'd1;
      endcase
   endfunction

endpackage

// File: rtl/sercfg_timer.sv
module sercfg_timer #(
   parameter int unsigned UNIT_CLKS = 2,
   parameter int unsigned MAX_UNITS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [1:0] units,
   output logic       zero
);
   localparam int unsigned CW = $clog2(MAX_UNITS * UNIT_CLKS + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(int'(units) * UNIT_CLKS - 1);
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/sercfg_txshift.sv
module sercfg_txshift #(
   parameter int unsigned AW = 12,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          shift,
   output logic          msb
);
   localparam int unsigned SW = AW + DW;

   logic [SW-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr <= '0;
      end else if (load) begin
         sr <= {addr, wdata};
      end else if (shift) begin
         sr <= {sr[SW-2:0], 1'b0};
      end
   end

   assign msb = sr[SW-1];

endmodule

// File: rtl/sercfg_rxcap.sv
module sercfg_rxcap #(
   parameter int unsigned DW        = 32,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sample,
   input  logic          din,
   output logic [DW-1:0] word
);
   generate
      if (LSB_FIRST) begin : g_lsb_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word <= '0;
            else if (sample) word <= {din, word[DW-1:1]};
         end
      end else begin : g_msb_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      word <= '0;
            else if (sample) word <= {word[DW-2:0], din};
         end
      end
   endgenerate

endmodule

// File: rtl/sercfg_host.sv
module sercfg_host
   import sercfg_pkg::*;
#(
   parameter int unsigned UNIT_CLKS = 2,
   parameter int unsigned AW        = 12,
   parameter int unsigned DW        = 32,
   parameter bit          LSB_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_start,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rsp_done,
   output logic [DW-1:0] rsp_rdata,
   output logic          sc_clk,
   output logic          sc_dout,
   output logic          sc_sel,
   output logic          sc_load,
   input  logic          sc_din
);
   localparam int unsigned BCW = $clog2(AW + DW + 1);

   generate
      if (UNIT_CLKS < 1) begin : g_bad_unit
         $error("UNIT_CLKS must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("AW must be at least 1");
      end
      if (DW < 2) begin : g_bad_dw
         $error("DW must be at least 2");
      end
   endgenerate

   seq_state_t     state, nxt;
   logic           wr_q;
   logic [BCW-1:0] bits_left;
   logic           tmr_zero, step, start_acc, tx_msb;

   assign start_acc = (state == ST_IDLE) && req_start;

   always_comb begin
      case (state)
         ST_IDLE:    step = req_start;
         ST_DONE:    step = 1'b1;
         default:    step = tmr_zero;
      endcase
   end

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:    nxt = req_write ? ST_SEL : ST_BIT_LO;
         ST_SEL:     nxt = ST_BIT_LO;
         ST_BIT_LO:  nxt = ST_BIT_HI;
         ST_BIT_HI:  nxt = (bits_left == BCW'(1)) ? ST_GAP : ST_BIT_LO;
         ST_GAP:     nxt = ST_LD_SET;
         ST_LD_SET:  nxt = ST_LD_HI;
         ST_LD_HI:   nxt = ST_LD_END;
         ST_LD_END:  nxt = wr_q ? ST_DONE : ST_RD_LO;
         ST_RD_LO:   nxt = ST_RD_HI;
         ST_RD_HI:   nxt = ST_RD_POST;
         ST_RD_POST: nxt = (bits_left == BCW'(1)) ? ST_DONE : ST_RD_LO;
         ST_DONE:    nxt = ST_IDLE;
         default:    nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         wr_q      <= 1'b0;
         bits_left <= '0;
      end else begin
         if (step) state <= nxt;
         if (start_acc) begin
            wr_q      <= req_write;
            bits_left <= req_write ? BCW'(AW + DW) : BCW'(AW);
         end else if (step && (state == ST_LD_END)) begin
            bits_left <= BCW'(DW);
         end else if (step && ((state == ST_BIT_HI) || (state == ST_RD_POST))) begin
            bits_left <= bits_left - 1'b1;
         end
      end
   end

   sercfg_timer #(
      .UNIT_CLKS (UNIT_CLKS),
      .MAX_UNITS (MAX_PHASE_UNITS)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (step && (nxt != ST_IDLE) && (nxt != ST_DONE)),
      .units (phase_units(nxt)),
      .zero  (tmr_zero)
   );

   sercfg_txshift #(
      .AW (AW),
      .DW (DW)
   ) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_acc),
      .addr  (req_addr),
      .wdata (req_wdata),
      .shift (step && (state == ST_BIT_HI)),
      .msb   (tx_msb)
   );

   sercfg_rxcap #(
      .DW        (DW),
      .LSB_FIRST (LSB_FIRST)
   ) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (step && (state == ST_RD_POST)),
      .din    (sc_din),
      .word   (rsp_rdata)
   );

   assign sc_clk   = (state == ST_BIT_HI) || (state == ST_LD_HI) || (state == ST_RD_HI);
   assign sc_load  = (state == ST_LD_SET) || (state == ST_LD_HI);
   assign sc_dout  = ((state == ST_BIT_LO) || (state == ST_BIT_HI)) && tx_msb;
   assign sc_sel   = wr_q && (state != ST_IDLE) && (state != ST_DONE);
   assign rsp_done = (state == ST_DONE);

endmodule

// File: rtl/sercfg_host_chk.sv
module sercfg_host_chk (
   input logic clk,
   input logic rst_n,
   input logic sc_clk,
   input logic sc_dout,
   input logic sc_sel,
   input logic sc_load,
   input logic rsp_done
);
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   a_r1_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!sc_clk && !sc_dout && !sc_sel && !sc_load));

   a_r5_load_data_low: assert property (@(posedge clk) disable iff (!rst_n)
      sc_load |-> !sc_dout);

   a_r5_load_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sc_load) |-> !sc_clk);

   a_r4_sel_drops_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sc_sel) |-> rsp_done);

endmodule

bind sercfg_host sercfg_host_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sc_clk   (sc_clk),
   .sc_dout  (sc_dout),
   .sc_sel   (sc_sel),
   .sc_load  (sc_load),
   .rsp_done (rsp_done)
);

// File: tb/test_sercfg_host.sv
module test_sercfg_host;
   localparam int U = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_start = 1'b0;
   logic        req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_done;
   logic [31:0] rsp_rdata;
   logic        sc_clk, sc_dout, sc_sel, sc_load;
   logic        sc_din = 1'b0;

   always #5 clk = ~clk;

   sercfg_host #(.UNIT_CLKS(U)) i_sercfg_host (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
      .rsp_rdata(rsp_rdata), .sc_clk(sc_clk), .sc_dout(sc_dout), .sc_sel(sc_sel),
      .sc_load(sc_load), .sc_din(sc_din)
   );

   typedef struct packed {
      logic        wr;
      logic [11:0] addr;
      logic [31:0] wdata;
      logic [31:0] rword;
   } item_t;

   item_t exp_q[$];
   int    n_tests = 0;
   int    n_fail = 0;
   int    done_cnt = 0;
   int    stray = 0;
   bit    finished = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor / serial target model
   logic        p_clk = 0, p_load = 0, p_done = 0;
   logic [43:0] rx = '0;
   int          nbits = 0, hi_cnt = 0, rd_idx = 0;
   bit          in_read = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (p_done) check(!rsp_done && !sc_clk && !sc_sel && !sc_load && !sc_dout,
                           "R7/R1 done width and quiet bus", {rsp_done, sc_clk, sc_sel, sc_load, sc_dout}, 0);
         if (sc_clk && !p_clk && !sc_load && !in_read) begin
            if (exp_q.size() == 0) stray++;
            else begin
               rx = {rx[42:0], sc_dout};
               nbits++;
               check(sc_sel == exp_q[0].wr, "R4 select level at bit", sc_sel, exp_q[0].wr);
            end
         end
         if (sc_clk) hi_cnt++;
         if (!sc_clk && p_clk) begin
            if (p_load) check(hi_cnt == 3*U, "R5 load clock high time", hi_cnt, 3*U);
            else if (in_read) begin
               check(hi_cnt == 2*U, "R6 read pulse high time", hi_cnt, 2*U);
               if (exp_q.size() != 0) sc_din = exp_q[0].rword[rd_idx];
               rd_idx++;
            end else check(hi_cnt == U, "R2 bit clock high time", hi_cnt, U);
            hi_cnt = 0;
         end
         if (sc_load && !p_load) begin
            check(!sc_dout && !sc_clk, "R5 load rises with clock and data low", {sc_clk, sc_dout}, 0);
            if (exp_q.size() == 0) stray++;
            else if (exp_q[0].wr) begin
               check(nbits == 44, "R3 write bit count", nbits, 44);
               check(rx[43:32] == exp_q[0].addr, "R2 write address MSB first", rx[43:32], exp_q[0].addr);
               check(rx[31:0] == exp_q[0].wdata, "R3 write data MSB first", rx[31:0], exp_q[0].wdata);
               check(sc_sel, "R4 select high at load on write", sc_sel, 1);
            end else begin
               check(nbits == 12, "R2 read address bit count", nbits, 12);
               check(rx[11:0] == exp_q[0].addr, "R2 read address MSB first", rx[11:0], exp_q[0].addr);
               check(!sc_sel, "R4 select low on read", sc_sel, 0);
            end
         end
         if (!sc_load && p_load && exp_q.size() != 0) begin
            in_read = !exp_q[0].wr;
            rd_idx = 0;
         end
         if (rsp_done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
               check(0, "R8 unexpected done", 1, 0);
            end else begin
               if (!exp_q[0].wr) begin
                  check(rd_idx == 32, "R6 read pulse count", rd_idx, 32);
                  check(rsp_rdata == exp_q[0].rword, "R6/R7 read word LSB first", rsp_rdata, exp_q[0].rword);
               end
               void'(exp_q.pop_front());
            end
            nbits = 0; rx = '0; in_read = 0; sc_din = 0;
         end
      end
      p_clk = sc_clk; p_load = sc_load; p_done = rsp_done;
   end

   task automatic run_txn(input logic wr, input logic [11:0] a, input logic [31:0] d, input logic [31:0] rw);
      int target;
      item_t it;
      it.wr = wr; it.addr = a; it.wdata = d; it.rword = rw;
      exp_q.push_back(it);
      target = done_cnt + 1;
      @(negedge clk);
      req_start = 1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_start = 0;
      while (done_cnt < target) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!sc_clk && !sc_dout && !sc_sel && !sc_load && !rsp_done, "R1 outputs low in reset",
            {sc_clk, sc_dout, sc_sel, sc_load, rsp_done}, 0);
      rst_n = 1;
      repeat (4) @(negedge clk);
      check(rsp_rdata == 0, "R1 read word cleared", rsp_rdata, 0);
      check(!sc_clk && !sc_sel && !sc_load && !sc_dout, "R1 idle bus low", {sc_clk, sc_sel, sc_load, sc_dout}, 0);

      run_txn(1, 12'hA5C, 32'hDEADBEEF, 0);
      run_txn(1, 12'h001, 32'h80000001, 0);
      run_txn(0, 12'hFFF, 0, 32'h12345678);
      run_txn(0, 12'h800, 0, 32'h80000001);
      run_txn(0, 12'h3C3, 0, 32'hFFFFFFFF);
      run_txn(0, 12'h000, 0, 32'h00000000);

      // R8: start while busy must be ignored
      begin
         item_t it;
         int target;
         it.wr = 1; it.addr = 12'h5A1; it.wdata = 32'h0F0F00FF; it.rword = 0;
         exp_q.push_back(it);
         target = done_cnt + 1;
         @(negedge clk);
         req_start = 1; req_write = 1; req_addr = 12'h5A1; req_wdata = 32'h0F0F00FF;
         @(negedge clk);
         req_start = 0;
         repeat (30) @(negedge clk);
         req_start = 1; req_write = 0; req_addr = 12'h111; req_wdata = 0;
         @(negedge clk);
         req_start = 0;
         while (done_cnt < target) @(negedge clk);
         repeat (60) @(negedge clk);
         check(done_cnt == target, "R8 single done for busy start", done_cnt, target);
         check(stray == 0, "R8 no stray bus activity", stray, 0);
         check(!sc_clk && !sc_sel && !sc_load, "R1 bus quiet after busy test", {sc_clk, sc_sel, sc_load}, 0);
      end

      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_tests++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule